// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write data hazards in a five-stage in-order pipeline without stalling. It compares the two source register indices of the instruction now in the execute stage with the destination indices of the two older instructions, which are held in the EX/MEM and MEM/WB pipeline registers. For each ALU operand it then produces a 2-bit select. The select chooses between the register-file value, the EX/MEM result and the MEM/WB write-back value. The same selects serve every instruction that reads registers in execute: arithmetic and logic operations, the base address and store data of memory accesses, and both compared operands of a conditional branch.

A second, independent path covers a load that is followed at once by a store of the loaded register. In that case the loaded word arrives in MEM/WB while the store is in the memory stage. A single select bit then routes the MEM/WB data onto the memory write-data bus. The unit is purely combinational. The multiplexers it steers and the stall logic for load-use hazards belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: `fwd_sel_a` is 2'b10 (take the EX/MEM result) when `exmem_wr_en` is 1, `exmem_dst_idx` is non-zero and equal to `ex_src1_idx`.
- R2: `fwd_sel_a` is 2'b01 (take the MEM/WB value) when `memwb_wr_en` is 1, `memwb_dst_idx` is non-zero and equal to `ex_src1_idx`, and the R1 condition does not hold.
- R3: When both the EX/MEM and the MEM/WB conditions hold for the same source, the select is 2'b10: the younger producer wins. The value 2'b11 never appears on either select.
- R4: `fwd_sel_b` follows the rules of R1, R2, R3, R5, R6 and R7 against `ex_src2_idx`, independently of operand A.
- R5: A producer whose write enable is 0 never causes forwarding, even when its destination index matches.
- R6: A destination index of 0 never causes forwarding on either ALU operand or on the store-data path, even when it is write-enabled and matches.
- R7: With no qualifying match a select is 2'b00 (register-file data).
- R8: `st_data_fwd` is 1 exactly when all of these hold: `mem_is_store` is 1, `memwb_is_load` is 1, `memwb_wr_en` is 1, and `memwb_dst_idx` is non-zero and equal to `mem_store_src_idx`.
- R9: `st_data_fwd` stays 0 when the MEM/WB producer is not a load (`memwb_is_load` 0) or the memory-stage instruction is not a store, whatever the indices are.
- R10: All outputs are combinational functions of the current inputs, with no state and no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1_idx | input | IDX_W | First source register index of the execute-stage instruction |
| ex_src2_idx | input | IDX_W | Second source register index of the execute-stage instruction |
| exmem_dst_idx | input | IDX_W | Destination index held in EX/MEM |
| exmem_wr_en | input | 1 | Register-write enable held in EX/MEM |
| memwb_dst_idx | input | IDX_W | Destination index held in MEM/WB |
| memwb_wr_en | input | 1 | Register-write enable held in MEM/WB |
| memwb_is_load | input | 1 | MEM/WB instruction writes back memory data (a load) |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_store_src_idx | input | IDX_W | Register index of the memory-stage store's data |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| st_data_fwd | output | 1 | 1 routes MEM/WB data to memory write data |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because no register lies between the inputs and the outputs. The bench applies each new input set shortly after a rising edge. At the following falling edge it compares all three outputs with a behavioural model, so each comparison sees settled values from exactly one stimulus. Directed vectors cover single hazards, double hazards, the disabled-writer case and the index-zero case. A long run with indices drawn from a narrow range then forces frequent partial and full matches on both operands and on the store path.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the operand forwarding logic.
// Assumes: select codes are fixed by the operand multiplexers downstream.
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,   // register-file read data
        FWD_WB  = 2'b01,   // MEM/WB write-back value
        FWD_MEM = 2'b10    // EX/MEM ALU result
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// Module: fwd_match
// Decides whether one producer stage supplies the value one consumer reads.
// Assumes: index 0 is the hard-wired zero register and is never a producer.
module fwd_match #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_wr,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    // Producer qualifies if it writes, targets a real register and matches.
    always_comb begin
        hit = dst_wr && (dst_idx != ZERO_IDX) && (dst_idx == src_idx);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Module: fwd_operand_sel
// Turns the two stage hits of one ALU operand into a select code.
// Assumes: EX/MEM holds the younger producer and so takes precedence.
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  logic       hit_mem,
    input  logic       hit_wb,
    output logic [1:0] sel
);
    fwd_sel_e sel_e;

    // Priority choice: younger EX/MEM first, then MEM/WB, else register file.
    always_comb begin
        if (hit_mem)      sel_e = FWD_MEM;
        else if (hit_wb)  sel_e = FWD_WB;
        else              sel_e = FWD_RF;
        sel = sel_e;
    end

    // Guard the encoding and the priority against the hit inputs.
    always_comb begin
        assert_sel_onehot0_R3: assert ($onehot0(sel))
            else $error("select carries both codes");
        if (hit_mem)
            assert_mem_wins_R3: assert (sel == 2'b10)
                else $error("EX/MEM hit lost priority");
        if (!hit_mem && !hit_wb)
            assert_idle_rf_R7: assert (sel == 2'b00)
                else $error("forwarding without a hit");
    end
endmodule

// File: rtl/fwd_ldst.sv
// Module: fwd_ldst
// Store-data bypass for a load directly followed by a store of its result.
// Assumes: the loaded word is present in MEM/WB while the store is in MEM.
module fwd_ldst #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ld_dst_idx,
    input  logic             ld_wr_en,
    input  logic             ld_is_load,
    input  logic             st_valid,
    input  logic [IDX_W-1:0] st_src_idx,
    output logic             st_fwd
);
    logic idx_hit;

    fwd_match #(.IDX_W(IDX_W)) u_match (
        .src_idx (st_src_idx),
        .dst_idx (ld_dst_idx),
        .dst_wr  (ld_wr_en),
        .hit     (idx_hit)
    );

    // Bypass only for a real load feeding a real store.
    always_comb begin
        st_fwd = idx_hit && ld_is_load && st_valid;
    end

    // The bypass must never fire outside a load-store pair.
    always_comb begin
        if (st_fwd) begin
            assert_pair_only_R9: assert (ld_is_load && st_valid)
                else $error("store bypass without load-store pair");
            assert_nonzero_dst_R6: assert (ld_dst_idx != '0)
                else $error("store bypass from zero register");
        end
    end
endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit (top)
// Operand forwarding for a five-stage pipeline: two ALU operand selects
// and one store-data select. Purely combinational; no clock or reset.
// Assumes: stall logic keeps load-use pairs apart before they reach EX.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_src1_idx,
    input  logic [IDX_W-1:0] ex_src2_idx,
    input  logic [IDX_W-1:0] exmem_dst_idx,
    input  logic             exmem_wr_en,
    input  logic [IDX_W-1:0] memwb_dst_idx,
    input  logic             memwb_wr_en,
    input  logic             memwb_is_load,
    input  logic             mem_is_store,
    input  logic [IDX_W-1:0] mem_store_src_idx,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             st_data_fwd
);
    localparam int NUM_SRC = 2;

    logic [IDX_W-1:0] src_idx [NUM_SRC];
    logic [1:0]       src_sel [NUM_SRC];
    logic [NUM_SRC-1:0] hit_mem;
    logic [NUM_SRC-1:0] hit_wb;

    // Gather the consumer indices into one array for the generate loop.
    always_comb begin
        src_idx[0] = ex_src1_idx;
        src_idx[1] = ex_src2_idx;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_match #(.IDX_W(IDX_W)) u_hit_mem (
            .src_idx (src_idx[g]),
            .dst_idx (exmem_dst_idx),
            .dst_wr  (exmem_wr_en),
            .hit     (hit_mem[g])
        );
        fwd_match #(.IDX_W(IDX_W)) u_hit_wb (
            .src_idx (src_idx[g]),
            .dst_idx (memwb_dst_idx),
            .dst_wr  (memwb_wr_en),
            .hit     (hit_wb[g])
        );
        fwd_operand_sel u_sel (
            .hit_mem (hit_mem[g]),
            .hit_wb  (hit_wb[g]),
            .sel     (src_sel[g])
        );
    end

    // Drive the operand select ports from the per-source results.
    always_comb begin
        fwd_sel_a = src_sel[0];
        fwd_sel_b = src_sel[1];
    end

    fwd_ldst #(.IDX_W(IDX_W)) u_ldst (
        .ld_dst_idx (memwb_dst_idx),
        .ld_wr_en   (memwb_wr_en),
        .ld_is_load (memwb_is_load),
        .st_valid   (mem_is_store),
        .st_src_idx (mem_store_src_idx),
        .st_fwd     (st_data_fwd)
    );

    // Port-level checks: each forward must trace back to a writing producer.
    always_comb begin
        if (fwd_sel_a == 2'b10)
            assert_a_mem_src_R1: assert (exmem_wr_en && exmem_dst_idx == ex_src1_idx)
                else $error("operand A forwarded from EX/MEM without producer");
        if (fwd_sel_a == 2'b01)
            assert_a_wb_src_R2: assert (memwb_wr_en && memwb_dst_idx == ex_src1_idx)
                else $error("operand A forwarded from MEM/WB without producer");
        if (fwd_sel_b == 2'b10)
            assert_b_mem_src_R4: assert (exmem_wr_en && exmem_dst_idx == ex_src2_idx)
                else $error("operand B forwarded from EX/MEM without producer");
        if (fwd_sel_b == 2'b01)
            assert_b_wb_src_R4: assert (memwb_wr_en && memwb_dst_idx == ex_src2_idx)
                else $error("operand B forwarded from MEM/WB without producer");
        if (fwd_sel_a != 2'b00)
            assert_a_nonzero_R6: assert (ex_src1_idx != '0)
                else $error("operand A forwarded for zero register");
        if (fwd_sel_b != 2'b00)
            assert_b_nonzero_R6: assert (ex_src2_idx != '0)
                else $error("operand B forwarded for zero register");
        if (!exmem_wr_en && !memwb_wr_en)
            assert_no_writer_R5: assert (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00 && !st_data_fwd)
                else $error("forwarding with no writing producer");
    end
endmodule

// File: tb/fwd_unit_bench.sv
// Bench for fwd_unit: behavioural reference compared every clock.
module fwd_unit_bench;
    localparam int IDX_W = 5;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [IDX_W-1:0] s1, s2, xd, wd, ss;
    logic xw, ww, wl, ms;
    logic [1:0] sel_a, sel_b;
    logic st_fwd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fwd_unit #(.IDX_W(IDX_W)) u_fwd_unit (
        .ex_src1_idx       (s1),
        .ex_src2_idx       (s2),
        .exmem_dst_idx     (xd),
        .exmem_wr_en       (xw),
        .memwb_dst_idx     (wd),
        .memwb_wr_en       (ww),
        .memwb_is_load     (wl),
        .mem_is_store      (ms),
        .mem_store_src_idx (ss),
        .fwd_sel_a         (sel_a),
        .fwd_sel_b         (sel_b),
        .st_data_fwd       (st_fwd)
    );

    // Reference: select for one source, written from the requirements.
    function automatic int ref_sel(int src);
        bit m, w;
        m = xw && (int'(xd) != 0) && (int'(xd) == src);
        w = ww && (int'(wd) != 0) && (int'(wd) == src);
        if (m) return 2;
        if (w) return 1;
        return 0;
    endfunction

    // Requirement tag that best describes the expected outcome for a source.
    function automatic string sel_tag(int src);
        bit rm, rw;
        rm = (int'(xd) == src) && xw;
        rw = (int'(wd) == src) && ww;
        if (src == 0 && (rm || rw)) return "R6";
        if (ref_sel(src) == 2) return (rw ? "R3" : "R1");
        if (ref_sel(src) == 1) return "R2";
        if ((int'(xd) == src) || (int'(wd) == src)) return "R5";
        return "R7";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (s1=%0d s2=%0d xd=%0d xw=%0b wd=%0d ww=%0b wl=%0b ms=%0b ss=%0d)",
                     tag, act, exp, s1, s2, xd, xw, wd, ww, wl, ms, ss);
        end
    endtask

    // Compare all outputs against the model; called at a falling edge (R10).
    task automatic compare_all();
        int ea, eb, es;
        string tb_tag;
        ea = ref_sel(int'(s1));
        eb = ref_sel(int'(s2));
        es = (ms && wl && ww && (int'(wd) != 0) && (wd == ss)) ? 1 : 0;
        check(sel_tag(int'(s1)), int'(sel_a), ea);
        tb_tag = (sel_tag(int'(s2)) == "R6") ? "R6" : "R4";
        check(tb_tag, int'(sel_b), eb);
        if (es == 1) check("R8", int'(st_fwd), es);
        else if (!wl || !ms) check("R9", int'(st_fwd), es);
        else if (int'(wd) == 0) check("R6", int'(st_fwd), es);
        else check("R8", int'(st_fwd), es);
    endtask

    // Apply one input set after the rising edge, check at the falling edge.
    task automatic apply(input int a1, a2, xdi, xwi, wdi, wwi, wli, msi, ssi);
        @(posedge clk);
        #2;
        s1 = a1[IDX_W-1:0]; s2 = a2[IDX_W-1:0];
        xd = xdi[IDX_W-1:0]; xw = xwi[0];
        wd = wdi[IDX_W-1:0]; ww = wwi[0];
        wl = wli[0]; ms = msi[0]; ss = ssi[IDX_W-1:0];
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        s1 = '0; s2 = '0; xd = '0; wd = '0; ss = '0;
        xw = 0; ww = 0; wl = 0; ms = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: idle inputs give register-file selects (R7).
        check("R7", int'(sel_a), 0);
        check("R7", int'(sel_b), 0);
        check("R9", int'(st_fwd), 0);
        rst_n = 1'b1;

        // R1: EX/MEM producer feeds operand A.
        apply(3, 4, 3, 1, 9, 1, 0, 0, 0);
        // R2: MEM/WB producer feeds operand A.
        apply(7, 4, 9, 1, 7, 1, 0, 0, 0);
        // R3: double hazard, EX/MEM wins.
        apply(5, 5, 5, 1, 5, 1, 0, 0, 0);
        // R4: operand B alone from each stage.
        apply(1, 6, 6, 1, 2, 1, 0, 0, 0);
        apply(1, 8, 3, 1, 8, 1, 0, 0, 0);
        // R5: matching producers with write disabled.
        apply(6, 6, 6, 0, 6, 0, 1, 1, 6);
        // R6: zero destination, enabled, matching.
        apply(0, 0, 0, 1, 0, 1, 1, 1, 0);
        // R8: load then store of same register.
        apply(2, 3, 9, 0, 12, 1, 1, 1, 12);
        // R9: non-load producer matches store data.
        apply(2, 3, 9, 0, 12, 1, 0, 1, 12);
        // R9: load matches but no store in MEM.
        apply(2, 3, 9, 0, 12, 1, 1, 0, 12);
        // R7: no matches anywhere.
        apply(10, 11, 12, 1, 13, 1, 1, 1, 14);
        // R10: back-to-back changes take effect in the same cycle.
        apply(31, 30, 31, 1, 30, 1, 1, 1, 30);
        apply(31, 30, 0, 0, 0, 0, 0, 0, 30);

        // Long run with narrow index ranges to force frequent matches.
        for (int i = 0; i < 4000; i++) begin
            int lim;
            lim = (i % 5 == 0) ? 31 : 3;
            apply($urandom_range(0, lim), $urandom_range(0, lim),
                  $urandom_range(0, lim), $urandom_range(0, 1),
                  $urandom_range(0, lim), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, lim));
        end
        finish_run();
    end
endmodule